// File: doc/BRIEF.md
# Static-Radix Fractional Arithmetic Unit

This unit does arithmetic on N-bit two's-complement fractions (sign bit plus N-1 fraction bits). No exponent is carried with the data. The program decides ahead of time where each value's binary point sits. It then asks the unit for single-bit rescaling steps where it needs them, so all scaling work is fixed and cheap in hardware.

The unit has three arithmetic paths, and a per-operation opcode selects one of them:

- **Add/subtract path.** It is one bit wider than the data. Either operand can be halved before the add, which lines up the binary points. The sum can be halved afterwards, which brings the one-bit growth back into N bits.
- **Multiply path.** It forms the product of two fractions, drops the duplicate sign bit, rounds half-up to N bits and saturates the single overflowing case.
- **Barrel shifter.** It does an arithmetic right shift by a programmable amount.

Operands, opcode and control bits are presented together with `valid_i`. The chosen result is registered and appears with `valid_o` one clock later.

Top module: `sfp_datapath`

## Requirements
- R1: With `op_i`=0 (add) and `ctrl_i`=0, `result_o` equals the low N bits of `a_i`+`b_i`, so an out-of-range sum wraps.
- R2: With `op_i`=1 (subtract) and `ctrl_i`=0, `result_o` equals the low N bits of `a_i`-`b_i`.
- R3: For add and subtract, `ctrl_i` bit 0 (or bit 1) replaces `a_i` (or `b_i`) by its 1-bit arithmetic right shift, dropping its LSB, before the operation.
- R4: For add and subtract, `ctrl_i` bit 2 makes `result_o` equal to bits N..1 of the N+1-bit sign-extended result, so no input pair overflows.
- R5: With `op_i`=2 (multiply), `result_o` equals floor(a·b·2^-(N-1) + 1/2), with `a_i` and `b_i` read as signed integers, i.e. the doubled product rounded half-up to N bits.
- R6: A multiply whose rounded result exceeds the largest positive value gives 0x7FFF (for N=16). The only such case is -1 × -1.
- R7: With `op_i`=3 (shift), `result_o` equals `a_i` arithmetically right-shifted by `shamt_i`, filling with the sign bit. A shift of 0 passes `a_i` through unchanged.
- R8: `ctrl_i` has no effect on multiply or shift. `shamt_i` has no effect on add, subtract or multiply. `b_i` has no effect on shift.
- R9: `valid_o` is high in exactly the cycle after a cycle with `valid_i` high. `result_o` holds its value while `valid_i` is low.
- R10: While `rst_ni` is low, `valid_o` is 0 and `result_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operands and opcode are presented this cycle |
| op_i | input | 2 | 0 add, 1 subtract, 2 multiply, 3 right shift |
| ctrl_i | input | 3 | Bit 0 halve A, bit 1 halve B, bit 2 halve sum |
| shamt_i | input | $clog2(W) | Shift distance for op 3 |
| a_i | input | W | Operand A (fraction) |
| b_i | input | W | Operand B (fraction) |
| valid_o | output | 1 | Result is new this cycle |
| result_o | output | W | Registered result |

## Verification
The assertions assume `valid_i` is low throughout reset. They also assume every input is a known value whenever `valid_i` is high. Every 2-bit opcode is a legal operation, so no opcode constraint is needed.

The bench drives all inputs on the falling edge and clears `valid_i` before releasing reset. Control bits that do not apply to an operation are driven with nonzero values on purpose, which exercises the "no effect" cases. While `valid_i` is low, the operands are changed to garbage to prove that the held result is not disturbed.

// File: rtl/sfp_pkg.sv
package sfp_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_MUL = 2'd2,
    OP_SHR = 2'd3
  } sfp_op_e;

  localparam int CTRL_W       = 3;
  localparam int CTRL_ALIGN_A = 0;
  localparam int CTRL_ALIGN_B = 1;
  localparam int CTRL_NORM    = 2;
endpackage

// File: rtl/sfp_addsub.sv
module sfp_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         align_a_i,
  input  logic         align_b_i,
  input  logic         norm_i,
  output logic [W-1:0] res_o
);
  localparam int XW = W + 1;

  logic signed [XW-1:0] xa, xb, sum;

  always_comb begin
    xa = $signed({a_i[W-1], a_i});
    xb = $signed({b_i[W-1], b_i});
    if (align_a_i) xa = xa >>> 1;
    if (align_b_i) xb = xb >>> 1;
    sum = sub_i ? (xa - xb) : (xa + xb);
    // guard bit absorbs growth; normalizer folds it back
    res_o = norm_i ? sum[XW-1:1] : sum[W-1:0];
  end
endmodule

// File: rtl/sfp_fmul.sv
module sfp_fmul #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);
  localparam int PW = 2 * W;
  localparam logic signed [PW-1:0] RND = PW'(1) << (W - 2);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

  logic signed [PW-1:0] prod, prod_r;
  logic signed [W:0]    kept;
  logic                 ovf;

  always_comb begin
    prod   = $signed(a_i) * $signed(b_i);
    prod_r = prod + RND;
    // 1-bit left normalize + truncate == shift right by W-1
    kept   = (W+1)'(prod_r >>> (W - 1));
    ovf    = !kept[W] && kept[W-1];
    res_o  = ovf ? MAX_POS : kept[W-1:0];
  end
endmodule

// File: rtl/sfp_barrel.sv
module sfp_barrel #(
  parameter int W = 16
) (
  input  logic [W-1:0]         a_i,
  input  logic [$clog2(W)-1:0] shamt_i,
  output logic [W-1:0]         res_o
);
  localparam int SHW = $clog2(W);

  logic [W-1:0] stg [SHW+1];

  assign stg[0] = a_i;

  for (genvar i = 0; i < SHW; i++) begin : g_stage
    localparam int STEP = 1 << i;
    assign stg[i+1] = shamt_i[i] ? W'($signed(stg[i]) >>> STEP) : stg[i];
  end

  assign res_o = stg[SHW];
endmodule

// File: rtl/sfp_datapath.sv
module sfp_datapath
  import sfp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [1:0]           op_i,
  input  logic [CTRL_W-1:0]    ctrl_i,
  input  logic [$clog2(W)-1:0] shamt_i,
  input  logic [W-1:0]         a_i,
  input  logic [W-1:0]         b_i,
  output logic                 valid_o,
  output logic [W-1:0]         result_o
);
  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

  sfp_op_e      op;
  logic [W-1:0] add_res, mul_res, shr_res, res_d, res_q;
  logic         valid_q;

  assign op = sfp_op_e'(op_i);

  sfp_addsub #(.W(W)) u_addsub (
    .a_i       (a_i),
    .b_i       (b_i),
    .sub_i     (op == OP_SUB),
    .align_a_i (ctrl_i[CTRL_ALIGN_A]),
    .align_b_i (ctrl_i[CTRL_ALIGN_B]),
    .norm_i    (ctrl_i[CTRL_NORM]),
    .res_o     (add_res)
  );

  sfp_fmul #(.W(W)) u_fmul (
    .a_i   (a_i),
    .b_i   (b_i),
    .res_o (mul_res)
  );

  sfp_barrel #(.W(W)) u_barrel (
    .a_i     (a_i),
    .shamt_i (shamt_i),
    .res_o   (shr_res)
  );

  always_comb begin
    unique case (op)
      OP_ADD, OP_SUB: res_d = add_res;
      OP_MUL:         res_d = mul_res;
      default:        res_d = shr_res;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) res_q <= res_d;
    end
  end

  assign valid_o  = valid_q;
  assign result_o = res_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R9
  AST_IDLE_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R9
  AST_HOLD_RESULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R9
  AST_MUL_SATURATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_MUL && a_i == MIN_NEG && b_i == MIN_NEG) |=> result_o == MAX_POS); // R6
  AST_NORM_DOUBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_ADD && ctrl_i == 3'b100 && a_i == b_i) |=> result_o == $past(a_i)); // R4
  AST_SHR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_SHR && shamt_i == '0) |=> result_o == $past(a_i)); // R7
  AST_SHR_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op == OP_SHR) |=> result_o[W-1] == $past(a_i[W-1])); // R7
endmodule

// File: tb/sfp_datapath_test.sv
module sfp_datapath_test;
  localparam int W  = 16;
  localparam int SW = $clog2(W);
  localparam int NV = 22;

  // {req, op, ctrl, shamt, a, b, expected}
  localparam logic [60:0] VEC [NV] = '{
    {4'd1, 2'd0, 3'd0, 4'd0, 16'h2000, 16'h1000, 16'h3000}, // R1
    {4'd1, 2'd0, 3'd0, 4'd0, 16'h7000, 16'h2000, 16'h9000}, // R1 wrap
    {4'd2, 2'd1, 3'd0, 4'd0, 16'h1000, 16'h3000, 16'hE000}, // R2
    {4'd2, 2'd1, 3'd0, 4'd0, 16'h8000, 16'h0001, 16'h7FFF}, // R2 wrap
    {4'd3, 2'd0, 3'd1, 4'd0, 16'h4000, 16'h1000, 16'h3000}, // R3
    {4'd3, 2'd0, 3'd2, 4'd0, 16'h1000, 16'h8000, 16'hD000}, // R3
    {4'd3, 2'd0, 3'd1, 4'd0, 16'h0003, 16'h0000, 16'h0001}, // R3 lsb drop
    {4'd3, 2'd0, 3'd1, 4'd0, 16'hFFFF, 16'h0000, 16'hFFFF}, // R3 neg
    {4'd4, 2'd0, 3'd4, 4'd0, 16'h7000, 16'h2000, 16'h4800}, // R4
    {4'd4, 2'd0, 3'd4, 4'd0, 16'h8000, 16'h8000, 16'h8000}, // R4
    {4'd4, 2'd1, 3'd4, 4'd0, 16'h8000, 16'h7FFF, 16'h8000}, // R4
    {4'd5, 2'd2, 3'd0, 4'd0, 16'h4000, 16'h4000, 16'h2000}, // R5
    {4'd5, 2'd2, 3'd0, 4'd0, 16'h8000, 16'h4000, 16'hC000}, // R5
    {4'd5, 2'd2, 3'd0, 4'd0, 16'h0001, 16'h4000, 16'h0001}, // R5 half up
    {4'd5, 2'd2, 3'd0, 4'd0, 16'h0001, 16'hC000, 16'h0000}, // R5 half up neg
    {4'd6, 2'd2, 3'd0, 4'd0, 16'h8000, 16'h8000, 16'h7FFF}, // R6
    {4'd7, 2'd3, 3'd0, 4'd4, 16'h8000, 16'h0000, 16'hF800}, // R7
    {4'd7, 2'd3, 3'd0, 4'd0, 16'h1234, 16'h0000, 16'h1234}, // R7
    {4'd7, 2'd3, 3'd0, 4'd15, 16'h8000, 16'h0000, 16'hFFFF}, // R7
    {4'd8, 2'd2, 3'd7, 4'd5, 16'h4000, 16'h4000, 16'h2000}, // R8
    {4'd8, 2'd3, 3'd7, 4'd1, 16'h4000, 16'hFFFF, 16'h2000}, // R8
    {4'd8, 2'd0, 3'd0, 4'd9, 16'h2000, 16'h1000, 16'h3000}  // R8
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [1:0]    op_i = '0;
  logic [2:0]    ctrl_i = '0;
  logic [SW-1:0] shamt_i = '0;
  logic [W-1:0]  a_i = '0;
  logic [W-1:0]  b_i = '0;
  logic          valid_o;
  logic [W-1:0]  result_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  sfp_datapath #(.W(W)) uut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_i),
    .op_i     (op_i),
    .ctrl_i   (ctrl_i),
    .shamt_i  (shamt_i),
    .a_i      (a_i),
    .b_i      (b_i),
    .valid_o  (valid_o),
    .result_o (result_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [2:0] ctrl, input logic [SW-1:0] sh,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk_i);
    valid_i = 1'b1; op_i = op; ctrl_i = ctrl; shamt_i = sh; a_i = a; b_i = b;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R10 valid", {{(W-1){1'b0}}, valid_o}, '0);
    check("R10 result", result_o, '0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [60:0] v;
      v = VEC[i];
      issue(v[56:55], v[54:52], v[51:48], v[47:32], v[31:16]);
      check($sformatf("R%0d vec %0d", v[60:57], i), result_o, v[15:0]);
      check("R9 valid_o after valid_i", {{(W-1){1'b0}}, valid_o}, 16'h0001);
    end

    // R9: idle cycle with garbage operands, result holds, valid low
    a_i = 16'hDEAD; b_i = 16'hBEEF; op_i = 2'd0;
    @(negedge clk_i);
    check("R9 idle valid", {{(W-1){1'b0}}, valid_o}, '0);
    check("R9 hold", result_o, 16'h3000);

    // R10: asynchronous reset clears a live result
    rst_ni = 1'b0;
    #1;
    check("R10 async result", result_o, '0);
    check("R10 async valid", {{(W-1){1'b0}}, valid_o}, '0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule